// File: doc/BRIEF.md
# Thread Block Barrier Unit

This unit coordinates barrier synchronization for the threads of a single thread block. When a thread reaches the barrier it sends an arrival on one of several arrival lanes, tagged with its thread index. The unit marks that thread as waiting and adds it to a running arrival count. When the count reaches the block size, every waiting thread is released together: one release pulse, and all waiting bits and the count cleared on the same edge. The unit is then ready for the next barrier.

The block size is given at run time, from 1 to 512 threads. The unit samples it only while no barrier is in progress, so a change made while threads are already waiting has no effect until the next barrier. Several arrivals may land in one cycle. Arrivals that would corrupt the count are dropped and flagged: a thread that is already waiting, the same thread on two lanes, or an index outside the block. The per-thread waiting mask is what the thread scheduler uses to hold threads stalled.

Top module: `thread_barrier_unit`

## Requirements
- R1: An accepted arrival for thread index t sets bit t of `wait_mask_o` and increments `arv_count_o` by one, both visible one clock after the edge that samples the arrival.
- R2: Arrivals on several lanes in the same cycle are all accepted and counted together. Lane l carries its thread index in bits [l*9+8 : l*9] of `arv_tid_i`.
- R3: On the edge where the count reaches the effective block size, all waiting bits and the count clear together. `release_o` is high for exactly that following cycle and low again afterwards unless another barrier completes.
- R4: Blocks of up to 512 threads are supported: a block of 512 releases only after all 512 distinct indices have arrived.
- R5: The effective block size is taken from `blk_size_i` while the count is zero and held while it is nonzero. A change to `blk_size_i` during a barrier has no effect on that barrier.
- R6: An arrival for a thread already waiting, or for an index already presented on a lower-numbered lane in the same cycle, is ignored. It leaves the mask and count unchanged and raises `arv_err_o` for one cycle.
- R7: An arrival whose index is not below the effective block size is ignored and raises `arv_err_o` for one cycle.
- R8: A `blk_size_i` of 0 is treated as 1, and a value above 512 is treated as 512.
- R9: Synchronous active-high reset clears the count, every waiting bit, `release_o` and `arv_err_o`. The first barrier after reset counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blk_size_i | input | 10 | Threads in the block (1..512, clamped) |
| arv_vld_i | input | 4 | Arrival valid, one bit per lane |
| arv_tid_i | input | 36 | Thread index per lane, 9 bits each, lane 0 in the low bits |
| wait_mask_o | output | 512 | Waiting bit per thread index |
| arv_count_o | output | 10 | Arrivals counted for the current barrier |
| release_o | output | 1 | One-cycle pulse releasing all waiting threads |
| arv_err_o | output | 1 | One-cycle flag for a rejected arrival |

## Verification
Every result of this block is registered on the same edge that samples the arrivals: the waiting bits, the count, the release pulse and the error flag all show the effect of a cycle's arrivals one clock later. The bench drives each cycle's arrivals and block size on the falling edge. It computes the expected mask, count, release and error from the requirements and queues them. A monitor compares one queued item 2 ns after each rising edge, so every comparison falls in the cycle where that result is due. Runs of idle items after a release confirm that the pulse lasts one cycle.

// File: rtl/tbar_pkg.sv
package tbar_pkg;

    localparam int DEF_MAX_THREADS = 512;
    localparam int DEF_LANES       = 4;

    // Outcome of one arrival lane in a cycle
    typedef enum logic [1:0] {
        LV_IDLE   = 2'd0,
        LV_TAKE   = 2'd1,
        LV_REJECT = 2'd2
    } lane_verdict_e;

    // Map a raw block size onto the legal range 1..limit
    function automatic int clamp_size(input int raw, input int limit);
        if (raw < 1) begin
            return 1;
        end
        if (raw > limit) begin
            return limit;
        end
        return raw;
    endfunction

endpackage

// File: rtl/tbar_arrival_filter.sv
module tbar_arrival_filter
    import tbar_pkg::*;
#(
    parameter int MAX_THREADS = DEF_MAX_THREADS,
    parameter int LANES       = DEF_LANES
) (
    input  logic [LANES-1:0]                      vld_i,
    input  logic [LANES*$clog2(MAX_THREADS)-1:0]  tid_i,
    input  logic [MAX_THREADS-1:0]                wait_i,
    input  logic [$clog2(MAX_THREADS+1)-1:0]      size_i,
    output logic [LANES-1:0]                      take_o,
    output logic                                  reject_o,
    output logic [$clog2(LANES+1)-1:0]            take_cnt_o
);

    localparam int TID_W  = $clog2(MAX_THREADS);
    localparam int SIZE_W = $clog2(MAX_THREADS + 1);
    localparam int ACC_W  = $clog2(LANES + 1);

    logic [LANES-1:0] rej;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TID_W-1:0] tid;
        logic             seen_before;
        logic             in_range;
        lane_verdict_e    verdict;

        assign tid      = tid_i[g*TID_W +: TID_W];
        assign in_range = (SIZE_W'(tid) < size_i);

        // Same index already offered on a lower lane this cycle
        always_comb begin
            seen_before = 1'b0;
            for (int j = 0; j < g; j++) begin
                if (vld_i[j] && (tid_i[j*TID_W +: TID_W] == tid)) begin
                    seen_before = 1'b1;
                end
            end
        end

        always_comb begin
            if (!vld_i[g]) begin
                verdict = LV_IDLE;
            end else if (in_range && !wait_i[tid] && !seen_before) begin
                verdict = LV_TAKE;
            end else begin
                verdict = LV_REJECT;
            end
        end

        assign take_o[g] = (verdict == LV_TAKE);
        assign rej[g]    = (verdict == LV_REJECT);
    end

    assign reject_o   = |rej;
    assign take_cnt_o = ACC_W'($countones(take_o));

endmodule

// File: rtl/tbar_counter.sv
module tbar_counter
    import tbar_pkg::*;
#(
    parameter int MAX_THREADS = DEF_MAX_THREADS,
    parameter int LANES       = DEF_LANES
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [$clog2(MAX_THREADS+1)-1:0]   cfg_size_i,
    input  logic [$clog2(LANES+1)-1:0]         take_cnt_i,
    output logic [$clog2(MAX_THREADS+1)-1:0]   eff_size_o,
    output logic [$clog2(MAX_THREADS+1)-1:0]   held_size_o,
    output logic [$clog2(MAX_THREADS+1)-1:0]   count_o,
    output logic                               fire_o,
    output logic                               release_o
);

    localparam int SIZE_W = $clog2(MAX_THREADS + 1);

    logic [SIZE_W-1:0] count_q;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] cfg_clamped;
    logic [SIZE_W:0]   sum;
    logic              idle;
    logic              rel_q;

    assign idle        = (count_q == '0);
    assign cfg_clamped = SIZE_W'(clamp_size(int'(cfg_size_i), MAX_THREADS));
    assign eff_size_o  = idle ? cfg_clamped : size_q;
    assign sum         = {1'b0, count_q} + (SIZE_W+1)'(take_cnt_i);
    assign fire_o      = (take_cnt_i != '0) && (sum == {1'b0, eff_size_o});

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            size_q  <= SIZE_W'(1);
            rel_q   <= 1'b0;
        end else begin
            rel_q <= fire_o;
            if (fire_o) begin
                count_q <= '0;
            end else begin
                count_q <= sum[SIZE_W-1:0];
            end
            if (idle) begin
                size_q <= cfg_clamped;
            end
        end
    end

    assign count_o     = count_q;
    assign held_size_o = size_q;
    assign release_o   = rel_q;

endmodule

// File: rtl/tbar_wait_mask.sv
module tbar_wait_mask
    import tbar_pkg::*;
#(
    parameter int MAX_THREADS = DEF_MAX_THREADS,
    parameter int LANES       = DEF_LANES
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [LANES-1:0]                      take_i,
    input  logic [LANES*$clog2(MAX_THREADS)-1:0]  tid_i,
    input  logic                                  fire_i,
    output logic [MAX_THREADS-1:0]                mask_o
);

    localparam int TID_W = $clog2(MAX_THREADS);

    logic [MAX_THREADS-1:0] mask_q;
    logic [MAX_THREADS-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        for (int l = 0; l < LANES; l++) begin
            if (take_i[l]) begin
                set_vec[tid_i[l*TID_W +: TID_W]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (fire_i) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_q | set_vec;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/thread_barrier_unit.sv
module thread_barrier_unit
    import tbar_pkg::*;
#(
    parameter int MAX_THREADS = DEF_MAX_THREADS,
    parameter int LANES       = DEF_LANES
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [$clog2(MAX_THREADS+1)-1:0]      blk_size_i,
    input  logic [LANES-1:0]                      arv_vld_i,
    input  logic [LANES*$clog2(MAX_THREADS)-1:0]  arv_tid_i,
    output logic [MAX_THREADS-1:0]                wait_mask_o,
    output logic [$clog2(MAX_THREADS+1)-1:0]      arv_count_o,
    output logic                                  release_o,
    output logic                                  arv_err_o
);

    localparam int SIZE_W = $clog2(MAX_THREADS + 1);
    localparam int ACC_W  = $clog2(LANES + 1);

    logic [LANES-1:0]  take;
    logic              reject;
    logic [ACC_W-1:0]  take_cnt;
    logic [SIZE_W-1:0] eff_size;
    logic [SIZE_W-1:0] held_size;
    logic              fire;
    logic              err_q;

    tbar_arrival_filter #(.MAX_THREADS(MAX_THREADS), .LANES(LANES)) filt_i (
        .vld_i      (arv_vld_i),
        .tid_i      (arv_tid_i),
        .wait_i     (wait_mask_o),
        .size_i     (eff_size),
        .take_o     (take),
        .reject_o   (reject),
        .take_cnt_o (take_cnt)
    );

    tbar_counter #(.MAX_THREADS(MAX_THREADS), .LANES(LANES)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_size_i  (blk_size_i),
        .take_cnt_i  (take_cnt),
        .eff_size_o  (eff_size),
        .held_size_o (held_size),
        .count_o     (arv_count_o),
        .fire_o      (fire),
        .release_o   (release_o)
    );

    tbar_wait_mask #(.MAX_THREADS(MAX_THREADS), .LANES(LANES)) mask_i (
        .clk    (clk),
        .rst    (rst),
        .take_i (take),
        .tid_i  (arv_tid_i),
        .fire_i (fire),
        .mask_o (wait_mask_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= reject;
        end
    end

    assign arv_err_o = err_q;

    // Count and mask are kept by separate modules and must agree
    AST_COUNT_MATCHES_MASK: assert property (@(posedge clk) disable iff (rst)
        $countones(wait_mask_o) == int'(arv_count_o)); // R1

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        release_o |-> (wait_mask_o == '0 && arv_count_o == '0)); // R3

    AST_COUNT_BELOW_SIZE: assert property (@(posedge clk) disable iff (rst)
        (arv_count_o != '0) |-> (arv_count_o < held_size)); // R4

    AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
        (arv_count_o != '0 && $past(arv_count_o) != '0) |-> $stable(held_size)); // R5

    AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (held_size != '0) && (int'(held_size) <= MAX_THREADS)); // R8

endmodule

// File: tb/thread_barrier_unit_tb_top.sv
module thread_barrier_unit_tb_top;

    localparam int MAXT  = 512;
    localparam int LANES = 4;
    localparam int TID_W = 9;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [9:0]             blk_size = 10'd4;
    logic [LANES-1:0]       vld = '0;
    logic [LANES*TID_W-1:0] tids = '0;
    logic [MAXT-1:0]        wait_mask;
    logic [9:0]             count;
    logic                   rel;
    logic                   err;

    always #4 clk = ~clk;

    thread_barrier_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .blk_size_i  (blk_size),
        .arv_vld_i   (vld),
        .arv_tid_i   (tids),
        .wait_mask_o (wait_mask),
        .arv_count_o (count),
        .release_o   (rel),
        .arv_err_o   (err)
    );

    typedef struct {
        logic [MAXT-1:0] mask;
        int              cnt;
        bit              rel;
        bit              err;
        string           tag;
    } exp_t;

    exp_t            sb_q[$];
    int              checks   = 0;
    int              failures = 0;
    bit              done     = 1'b0;
    logic [MAXT-1:0] r_mask   = '0;
    int              r_cnt    = 0;
    int              r_size   = 1;

    function automatic int tb_clamp(input int raw);
        if (raw == 0) return 1;
        if (raw > MAXT) return MAXT;
        return raw;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic drive(input int size, input logic [3:0] v,
                         input int t0, input int t1, input int t2, input int t3,
                         input string tag);
        int              tl[4];
        int              eff;
        int              acc;
        bit              e_err;
        bit              e_rel;
        logic [MAXT-1:0] add;
        exp_t            it;
        tl = '{t0, t1, t2, t3};
        @(negedge clk);
        blk_size = 10'(size);
        vld      = v;
        tids     = {9'(t3), 9'(t2), 9'(t1), 9'(t0)};
        eff = (r_cnt == 0) ? tb_clamp(size) : r_size;
        if (r_cnt == 0) r_size = eff;
        acc = 0; e_err = 0; e_rel = 0; add = '0;
        for (int l = 0; l < 4; l++) begin
            if (v[l]) begin
                if (tl[l] < eff && !r_mask[tl[l]] && !add[tl[l]]) begin
                    add[tl[l]] = 1'b1;
                    acc++;
                end else begin
                    e_err = 1'b1;
                end
            end
        end
        if (acc > 0 && r_cnt + acc == eff) begin
            r_mask = '0; r_cnt = 0; e_rel = 1'b1;
        end else begin
            r_mask = r_mask | add; r_cnt = r_cnt + acc;
        end
        it.mask = r_mask; it.cnt = r_cnt; it.rel = e_rel; it.err = e_err; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int size, input int n, input string tag);
        for (int k = 0; k < n; k++) drive(size, 4'b0000, 0, 0, 0, 0, tag);
    endtask

    task automatic check_now(input string tag);
        checks++;
        if (wait_mask != '0 || count != 0 || rel !== 1'b0 || err !== 1'b0) begin
            failures++;
            $display("FAIL %s: mask_nonzero=%0d cnt=%0d rel=%0d err=%0d expected 0 0 0 0",
                     tag, (wait_mask != '0), count, rel, err);
        end
    endtask

    // Monitor: compares one queued item per cycle, shortly after the edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (wait_mask !== e.mask || int'(count) != e.cnt || rel !== e.rel || err !== e.err) begin
                failures++;
                $display("FAIL %s: mask=%h cnt=%0d rel=%0d err=%0d expected mask=%h cnt=%0d rel=%0d err=%0d",
                         e.tag, wait_mask, count, rel, err, e.mask, e.cnt, e.rel, e.err);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_now("R9 reset state");

        // R1 single arrivals, R3 release on the fourth
        drive(4, 4'b0001, 0, 0, 0, 0, "R1 first arrival");
        drive(4, 4'b0001, 1, 0, 0, 0, "R1 second arrival");
        drive(4, 4'b0001, 2, 0, 0, 0, "R1 third arrival");
        drive(4, 4'b0001, 3, 0, 0, 0, "R3 last arrival releases");
        idle(4, 2, "R3 pulse ends");

        // R2 four lanes at once
        drive(8, 4'b1111, 0, 1, 2, 3, "R2 four lanes");
        drive(8, 4'b1111, 7, 6, 5, 4, "R2 R3 four lanes release");
        idle(8, 1, "R3 idle after release");

        // R6 duplicates, R7 out-of-range
        drive(6, 4'b0011, 0, 1, 0, 0, "R2 two lanes");
        drive(6, 4'b0001, 1, 0, 0, 0, "R6 already waiting");
        drive(6, 4'b0110, 0, 2, 2, 0, "R6 same index two lanes");
        drive(6, 4'b0001, 6, 0, 0, 0, "R7 index equal to size");
        drive(6, 4'b1000, 0, 0, 0, 9, "R7 index above size");
        drive(6, 4'b1011, 3, 4, 0, 1, "R6 mixed accept and reject");
        drive(6, 4'b0001, 5, 0, 0, 0, "R3 release size 6");
        idle(6, 1, "R6 error cleared");

        // R5 size change during a barrier is ignored
        drive(3, 4'b0001, 0, 0, 0, 0, "R5 start size 3");
        drive(2, 4'b0001, 1, 0, 0, 0, "R5 size change ignored");
        drive(2, 4'b0001, 2, 0, 0, 0, "R5 release at held size");
        drive(2, 4'b0001, 0, 0, 0, 0, "R5 new size taken");
        drive(2, 4'b0001, 1, 0, 0, 0, "R5 release at new size");

        // R8 clamping, back-to-back single-thread barriers
        drive(0, 4'b0001, 0, 0, 0, 0, "R8 size zero as one");
        drive(0, 4'b0001, 0, 0, 0, 0, "R3 back-to-back release");
        idle(0, 1, "R3 pulse ends");
        for (int k = 0; k < 128; k++) begin
            drive(700, 4'b1111, 4*k, 4*k+1, 4*k+2, 4*k+3, "R4 R8 full 512 block");
        end
        idle(700, 1, "R4 after full release");
        drive(512, 4'b0001, 511, 0, 0, 0, "R4 top index accepted");
        idle(512, 2, "R4 partial barrier holds");

        // R9 reset mid-barrier
        @(negedge clk);
        vld = '0;
        rst = 1'b1;
        r_mask = '0; r_cnt = 0; r_size = 1;
        @(negedge clk);
        rst = 1'b0;
        check_now("R9 reset mid-barrier");
        drive(4, 4'b0001, 2, 0, 0, 0, "R9 count restarts");
        idle(4, 3, "R9 idle");

        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule